// File: doc/BRIEF.md
# Composite Energy Frame Transmitter

This block takes a 16-bit beam energy value and a set of system status flags and turns them into one 16-bit composite status word. It sends that word as a framed, Manchester-coded serial stream to sixteen downstream processing cards at once. The energy is reduced linearly to one of 32 levels. The level is its upper five bits. The block packs the level with an error flag, a card soft-reset request, a system-under-test flag, two beam-info flags, two permit-line test flags and a 4-bit target card number. The card number picks the card that is made to provoke a dump during a test.

Each frame carries four parts in a fixed order. It starts with an 8-bit header, then the composite word, then a field of the last input toggle value followed by three zero bits, and ends with a 4-bit CRC. In test mode an operator-supplied energy can replace the real one. When both incoming energy links are reported broken, the block ignores every other input and sends a fixed safe word. That word carries the highest level, the error flag and both beam-info flags set. A new frame starts at a fixed period, and the block samples all inputs once at the start of each frame.

Top module: `energy_frame_tx`

## Requirements
- R1: The energy level in the word is the upper 5 bits of the selected 16-bit energy (linear, 0 to 31).
- R2: Composite word bit positions: [15:11] level, [10] error, [9] card soft reset, [8] system under test, [7] unmaskable beam info, [6] maskable beam info, [5] unmaskable line test, [4] maskable line test, [3:0] target card number.
- R3: With `test_mode`=1 and `subst_en`=1, the level is taken from `subst_energy` instead of `energy_in`.
- R4: With `test_mode`=0, `subst_en` and `subst_energy` have no effect on the frame.
- R5: With `links_broken`=1 the word is 16'hFCC0 (level 31, error 1, both beam-info bits 1, all else 0), regardless of every other flag, energy and substitution input.
- R6: A frame is 32 bits sent MSB first: header 8'b1001_0000, then word[15:0], then the toggle value, then 3'b000, then the CRC.
- R7: The CRC is the 4-bit remainder of the first 28 frame bits under x^4+x+1, with initial value 0.
- R8: Each bit is coded as two halves of HALF_BIT_CYCLES clocks: a 1 is high then low, and a 0 is low then high. The line is low outside the 32 frame bits.
- R9: All NUM_RX outputs carry the same waveform in every cycle.
- R10: Frames start every 2*HALF_BIT_CYCLES*SLOT_BITS clocks. Inputs are sampled once at the frame start, and changes during a frame affect only the next one.
- R11: While reset is active, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| energy_in | input | 16 | Selected beam energy |
| energy_err | input | 1 | Energy error flag |
| soft_reset | input | 1 | Soft-reset request to the processing cards |
| under_test | input | 1 | System-under-test flag |
| info_unmask | input | 1 | Unmaskable beam info |
| info_mask | input | 1 | Maskable beam info |
| ltest_unmask | input | 1 | Unmaskable permit line test |
| ltest_mask | input | 1 | Maskable permit line test |
| card_sel | input | 4 | Target card number for test dumps |
| toggle_in | input | 1 | Latest incoming toggle value |
| test_mode | input | 1 | Test mode enable |
| subst_en | input | 1 | Use substitute energy (test mode only) |
| subst_energy | input | 16 | Substitute energy value |
| links_broken | input | 1 | Both incoming links broken |
| tx_out | output | 16 | Serial line copied to each receiver |

## Verification
Two functions can meet on the same frame: the broken-link safe word and test-mode energy substitution. The bench provokes this by raising `links_broken` while `test_mode` and `subst_en` are set and every flag is driven to the opposite of its safe value. It decodes the frame from the line and requires exactly 16'hFCC0 with a matching CRC. It also changes the inputs right after a frame has started. It then requires the running frame to keep the old contents and the next frame to carry the new ones.

// File: rtl/efx_pkg.sv
// Shared types and helpers for the composite energy frame transmitter.
// Assumes the composite word layout is fixed at 16 bits.
package efx_pkg;

    localparam int LEVEL_BITS = 5;
    localparam int WORD_BITS  = 16;
    localparam int FRAME_BITS = 32;
    localparam logic [7:0]  FRAME_HDR = 8'b1001_0000;
    localparam logic [15:0] SAFE_WORD = 16'hFCC0;

    typedef struct packed {
        logic [LEVEL_BITS-1:0] level;
        logic                  err;
        logic                  soft_rst;
        logic                  sys_test;
        logic                  info_u;
        logic                  info_m;
        logic                  ltest_u;
        logic                  ltest_m;
        logic [3:0]            card;
    } comp_word_t;

    // Serial CRC over 28 bits, MSB first, polynomial x^4+x+1, seed 0.
    function automatic logic [3:0] crc4_calc(input logic [27:0] data);
        logic [3:0] c;
        logic       fb;
        c = 4'd0;
        for (int i = 27; i >= 0; i--) begin
            fb = data[i] ^ c[3];
            c  = {c[2:0], 1'b0} ^ ({4{fb}} & 4'b0011);
        end
        return c;
    endfunction

endpackage

// File: rtl/efx_level_conv.sv
// Energy-to-level conversion with test-only substitution.
// Assumes ENERGY_BITS >= LEVEL_BITS; the scale is linear (upper bits).
module efx_level_conv #(
    parameter int ENERGY_BITS = 16,
    parameter int LEVEL_BITS  = 5
) (
    input  logic [ENERGY_BITS-1:0] energy_in,
    input  logic [ENERGY_BITS-1:0] subst_energy,
    input  logic                   test_mode,
    input  logic                   subst_en,
    output logic [LEVEL_BITS-1:0]  level
);

    localparam int SHIFT = ENERGY_BITS - LEVEL_BITS;

    logic [ENERGY_BITS-1:0] chosen;

    // Pick the substitute only when test mode permits it, then scale.
    always_comb begin
        chosen = (test_mode && subst_en) ? subst_energy : energy_in;
        level  = LEVEL_BITS'(chosen >> SHIFT);
    end

endmodule

// File: rtl/efx_compose.sv
// Packs level and status flags into the composite word.
// Assumes the broken-link indication overrides every other input.
module efx_compose
    import efx_pkg::*;
(
    input  logic [LEVEL_BITS-1:0] level,
    input  logic                  energy_err,
    input  logic                  soft_reset,
    input  logic                  under_test,
    input  logic                  info_unmask,
    input  logic                  info_mask,
    input  logic                  ltest_unmask,
    input  logic                  ltest_mask,
    input  logic [3:0]            card_sel,
    input  logic                  links_broken,
    output comp_word_t            word
);

    // Build the normal word or substitute the fixed safe word.
    always_comb begin
        if (links_broken) begin
            word = comp_word_t'(SAFE_WORD);
        end else begin
            word.level    = level;
            word.err      = energy_err;
            word.soft_rst = soft_reset;
            word.sys_test = under_test;
            word.info_u   = info_unmask;
            word.info_m   = info_mask;
            word.ltest_u  = ltest_unmask;
            word.ltest_m  = ltest_mask;
            word.card     = card_sel;
        end
    end

endmodule

// File: rtl/efx_frame_build.sv
// Assembles the 32-bit frame: header, word, toggle field, CRC-4.
// Assumes the CRC covers the 28 bits ahead of it.
module efx_frame_build
    import efx_pkg::*;
(
    input  logic [WORD_BITS-1:0]  word,
    input  logic                  toggle,
    output logic [FRAME_BITS-1:0] frame
);

    logic [27:0] body;

    // Concatenate the fields and append their CRC.
    always_comb begin
        body  = {FRAME_HDR, word, toggle, 3'b000};
        frame = {body, crc4_calc(body)};
    end

endmodule

// File: rtl/efx_serializer.sv
// Frame-period timer, shift register and Manchester coder.
// Assumes SLOT_BITS > FRAME_BITS so every slot ends with an idle gap.
// A 1 is sent high-then-low; the line idles low outside the frame.
module efx_serializer #(
    parameter int HALF_BIT_CYCLES = 125,
    parameter int SLOT_BITS       = 1000,
    parameter int FRAME_BITS      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FRAME_BITS-1:0] frame_next,
    output logic                  line,
    output logic                  load,
    output logic                  in_frame,
    output logic [FRAME_BITS-1:0] frame_bits
);

    localparam int HW = (HALF_BIT_CYCLES > 1) ? $clog2(HALF_BIT_CYCLES) : 1;
    localparam int BW = $clog2(SLOT_BITS + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_BIT_CYCLES - 1);
    localparam logic [BW-1:0] SLOT_LAST = BW'(SLOT_BITS - 1);
    localparam logic [BW-1:0] FRM_LEN   = BW'(FRAME_BITS);

    logic [HW-1:0] half_cnt;
    logic          phase;
    logic [BW-1:0] bit_idx;
    logic          half_end;
    logic          bit_end;
    logic          line_c;

    // Decode timer events and the next line level.
    always_comb begin
        half_end = (half_cnt == HALF_LAST);
        bit_end  = half_end && phase;
        load     = bit_end && (bit_idx == SLOT_LAST);
        in_frame = (bit_idx < FRM_LEN);
        line_c   = in_frame && (frame_bits[FRAME_BITS-1] ^ phase);
    end

    // Advance half-bit, bit and slot counters; reset parks at slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            phase    <= 1'b1;
            bit_idx  <= SLOT_LAST;
        end else if (half_end) begin
            half_cnt <= '0;
            phase    <= ~phase;
            if (phase) begin
                bit_idx <= (bit_idx == SLOT_LAST) ? '0 : bit_idx + 1'b1;
            end
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    // Capture a new frame at slot start, shift one bit per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_bits <= '0;
        end else if (load) begin
            frame_bits <= frame_next;
        end else if (bit_end) begin
            frame_bits <= {frame_bits[FRAME_BITS-2:0], 1'b0};
        end
    end

    // Register the line so the outputs are glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= 1'b0;
        end else begin
            line <= line_c;
        end
    end

endmodule

// File: rtl/energy_frame_tx.sv
// Top level: converts energy, builds the composite frame and drives
// the same Manchester line to NUM_RX receivers.
// Assumes inputs are synchronous to clk; they are sampled at frame start.
module energy_frame_tx
    import efx_pkg::*;
#(
    parameter int ENERGY_BITS     = 16,
    parameter int NUM_RX          = 16,
    parameter int HALF_BIT_CYCLES = 125,
    parameter int SLOT_BITS       = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ENERGY_BITS-1:0] energy_in,
    input  logic                   energy_err,
    input  logic                   soft_reset,
    input  logic                   under_test,
    input  logic                   info_unmask,
    input  logic                   info_mask,
    input  logic                   ltest_unmask,
    input  logic                   ltest_mask,
    input  logic [3:0]             card_sel,
    input  logic                   toggle_in,
    input  logic                   test_mode,
    input  logic                   subst_en,
    input  logic [ENERGY_BITS-1:0] subst_energy,
    input  logic                   links_broken,
    output logic [NUM_RX-1:0]      tx_out
);

    logic [LEVEL_BITS-1:0] level;
    comp_word_t            comp_word;
    logic [FRAME_BITS-1:0] frame_next;
    logic [FRAME_BITS-1:0] frame_bits;
    logic                  line;
    logic                  load;
    logic                  in_frame;

    efx_level_conv #(
        .ENERGY_BITS (ENERGY_BITS),
        .LEVEL_BITS  (LEVEL_BITS)
    ) u_conv (
        .energy_in    (energy_in),
        .subst_energy (subst_energy),
        .test_mode    (test_mode),
        .subst_en     (subst_en),
        .level        (level)
    );

    efx_compose u_comp (
        .level        (level),
        .energy_err   (energy_err),
        .soft_reset   (soft_reset),
        .under_test   (under_test),
        .info_unmask  (info_unmask),
        .info_mask    (info_mask),
        .ltest_unmask (ltest_unmask),
        .ltest_mask   (ltest_mask),
        .card_sel     (card_sel),
        .links_broken (links_broken),
        .word         (comp_word)
    );

    efx_frame_build u_build (
        .word   (comp_word),
        .toggle (toggle_in),
        .frame  (frame_next)
    );

    efx_serializer #(
        .HALF_BIT_CYCLES (HALF_BIT_CYCLES),
        .SLOT_BITS       (SLOT_BITS),
        .FRAME_BITS      (FRAME_BITS)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_next (frame_next),
        .line       (line),
        .load       (load),
        .in_frame   (in_frame),
        .frame_bits (frame_bits)
    );

    // Copy the single coded line to every receiver port.
    generate
        for (genvar g = 0; g < NUM_RX; g++) begin : g_fan
            assign tx_out[g] = line;
        end
    endgenerate

endmodule

// File: rtl/efx_checker.sv
// Assertion checker for energy_frame_tx, attached with bind.
// Assumes it sees the top's internal word, frame and timer nets.
module efx_checker #(
    parameter int ENERGY_BITS = 16,
    parameter int NUM_RX      = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_RX-1:0]      tx_out,
    input logic                   links_broken,
    input logic                   test_mode,
    input logic [ENERGY_BITS-1:0] energy_in,
    input logic [15:0]            comp_word,
    input logic [31:0]            frame_bits,
    input logic                   load,
    input logic                   in_frame
);

    localparam int SHIFT = ENERGY_BITS - 5;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |=> (tx_out == '0)); // R8

    AST_BROKEN_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        links_broken |-> (comp_word == 16'hFCC0)); // R5

    AST_SUBST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !links_broken)
            |-> ((comp_word >> 11) == 16'(energy_in >> SHIFT))); // R4

    AST_HEADER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((frame_bits >> 24) == 32'h90)); // R6

    AST_LOAD_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !in_frame); // R10

endmodule

bind energy_frame_tx efx_checker #(
    .ENERGY_BITS (ENERGY_BITS),
    .NUM_RX      (NUM_RX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_out       (tx_out),
    .links_broken (links_broken),
    .test_mode    (test_mode),
    .energy_in    (energy_in),
    .comp_word    (comp_word),
    .frame_bits   (frame_bits),
    .load         (load),
    .in_frame     (in_frame)
);

// File: tb/energy_frame_tx_tb.sv
`timescale 1ns/1ps
// Directed bench: decodes the Manchester line and compares whole frames.
module energy_frame_tx_tb;

    localparam int H    = 4;
    localparam int SLOT = 40;
    localparam int NRX  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] energy_in = '0;
    logic        energy_err = 0, soft_reset = 0, under_test = 0;
    logic        info_unmask = 0, info_mask = 0;
    logic        ltest_unmask = 0, ltest_mask = 0;
    logic [3:0]  card_sel = '0;
    logic        toggle_in = 0, test_mode = 0, subst_en = 0;
    logic [15:0] subst_energy = '0;
    logic        links_broken = 0;
    logic [NRX-1:0] tx;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    energy_frame_tx #(
        .ENERGY_BITS(16), .NUM_RX(NRX), .HALF_BIT_CYCLES(H), .SLOT_BITS(SLOT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .energy_in(energy_in),
        .energy_err(energy_err), .soft_reset(soft_reset),
        .under_test(under_test), .info_unmask(info_unmask),
        .info_mask(info_mask), .ltest_unmask(ltest_unmask),
        .ltest_mask(ltest_mask), .card_sel(card_sel), .toggle_in(toggle_in),
        .test_mode(test_mode), .subst_en(subst_en),
        .subst_energy(subst_energy), .links_broken(links_broken),
        .tx_out(tx)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // CRC by polynomial long division of data*x^4 by x^4+x+1 (R7).
    function automatic logic [3:0] ref_crc(input logic [27:0] d);
        logic [31:0] r;
        r = {d, 4'b0000};
        for (int i = 31; i >= 4; i--) begin
            if (r[i]) r[i -: 5] = r[i -: 5] ^ 5'b10011;
        end
        return r[3:0];
    endfunction

    function automatic logic [31:0] ref_frame(input logic [15:0] w,
                                              input logic t);
        logic [27:0] b;
        b = {8'b1001_0000, w, t, 3'b000};
        return {b, ref_crc(b)};
    endfunction

    // Word expected from the current inputs under R1..R5.
    function automatic logic [15:0] ref_word();
        logic [15:0] e;
        if (links_broken) return 16'hFCC0;
        e = (test_mode && subst_en) ? subst_energy : energy_in;
        return {e[15:11], energy_err, soft_reset, under_test, info_unmask,
                info_mask, ltest_unmask, ltest_mask, card_sel};
    endfunction

    // Decode one frame whose first rising edge has just occurred.
    task automatic decode_body(output logic [31:0] f);
        logic a, b;
        bit manch_ok = 1, same_ok = 1;
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            a = tx[0];
            if (tx != {NRX{a}}) same_ok = 0;
            repeat (H) @(negedge clk);
            b = tx[0];
            if (tx != {NRX{b}}) same_ok = 0;
            if (b == a) manch_ok = 0;
            f[31-i] = a;
            repeat (H) @(negedge clk);
        end
        check(manch_ok, "R8 manchester halves", 32'(manch_ok), 32'd1);
        check(same_ok, "R9 receivers identical", 32'(same_ok), 32'd1);
        check(tx == '0, "R8 idle low after frame", 32'(tx), 32'd0);
    endtask

    task automatic decode_frame(output logic [31:0] f);
        @(posedge tx[0]);
        decode_body(f);
    endtask

    // Apply settings already made, skip one frame, check the next one.
    task automatic expect_frame(input string req);
        logic [31:0] f, e;
        e = ref_frame(ref_word(), toggle_in);
        decode_frame(f);
        decode_frame(f);
        check(f == e, req, f, e);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(tx == '0, "R11 outputs low in reset", 32'(tx), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_normal();
        @(negedge clk);
        energy_in = 16'h0000; card_sel = 4'h0;
        expect_frame("R1 R6 R7 zero energy");
        @(negedge clk);
        energy_in = 16'hFFFF; energy_err = 1; info_unmask = 1; card_sel = 4'hF;
        expect_frame("R1 R2 full energy");
        @(negedge clk);
        energy_in = 16'h5A5A; energy_err = 0; soft_reset = 1; under_test = 1;
        info_unmask = 0; info_mask = 1; ltest_unmask = 1; ltest_mask = 0;
        card_sel = 4'h9;
        expect_frame("R2 flags pattern A");
        @(negedge clk);
        energy_in = 16'h87FF; soft_reset = 0; under_test = 0; info_mask = 0;
        ltest_unmask = 0; ltest_mask = 1; card_sel = 4'h6;
        expect_frame("R1 R2 flags pattern B");
    endtask

    task automatic t_toggle();
        @(negedge clk);
        toggle_in = 1;
        expect_frame("R6 toggle one");
        @(negedge clk);
        toggle_in = 0;
        expect_frame("R6 toggle zero");
    endtask

    task automatic t_subst();
        @(negedge clk);
        energy_in = 16'hF000; test_mode = 1; subst_en = 1;
        subst_energy = 16'h3800;
        expect_frame("R3 substitute level 7");
        @(negedge clk);
        test_mode = 0;
        expect_frame("R4 substitution ignored outside test");
        @(negedge clk);
        test_mode = 1; subst_en = 0;
        expect_frame("R3 test mode without substitute");
        test_mode = 0;
    endtask

    task automatic t_broken();
        @(negedge clk);
        energy_in = 16'h0000; energy_err = 0; soft_reset = 1; under_test = 1;
        info_unmask = 0; info_mask = 0; ltest_unmask = 1; ltest_mask = 1;
        card_sel = 4'hA; test_mode = 1; subst_en = 1; subst_energy = 16'h0800;
        links_broken = 1; toggle_in = 1;
        expect_frame("R5 safe word beats substitution");
        @(negedge clk);
        links_broken = 0; test_mode = 0; subst_en = 0;
        expect_frame("R5 recovery after broken link");
    endtask

    task automatic t_timing();
        logic [31:0] f, e;
        realtime t0, t1;
        @(negedge clk);
        energy_in = 16'h1234; card_sel = 4'h3; toggle_in = 0;
        decode_frame(f);
        e = ref_frame(ref_word(), toggle_in);
        @(posedge tx[0]);
        t0 = $realtime;
        energy_in = 16'hC000; card_sel = 4'hC; toggle_in = 1;
        decode_body(f);
        check(f == e, "R10 frame held against input change", f, e);
        e = ref_frame(ref_word(), toggle_in);
        @(posedge tx[0]);
        t1 = $realtime;
        check((t1 - t0) == real'(SLOT * 2 * H * 4), "R10 frame period",
              32'(int'(t1 - t0)), 32'(SLOT * 2 * H * 4));
        decode_body(f);
        check(f == e, "R10 next frame takes new inputs", f, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_toggle();
        t_subst();
        t_broken();
        t_timing();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule